// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two operands one bit position per clock. A single one-bit full-adder cell is reused in every cycle. A carry flip-flop carries the result of each bit position into the next one. When a load strobe arrives while the block is idle, it captures both operands into shift registers and clears the carry. It then adds bit 0 first and moves upward through the bits. Each sum bit enters a result shift register at the top of the active field. After the last bit, the sum therefore sits right-aligned in the result.

A length-select input chooses the operand length at load time: a full word (`WORD_W` bits, 32 by default) or a byte (`BYTE_W` bits, 8 by default). The latency equals the operand length in clock cycles. When the addition completes, the block raises a single-cycle done pulse. The sum and the final carry then stay unchanged until the next accepted load. The block does not subtract, does not flag overflow and does not overlap operations.

Top module: `serial_word_adder`

## Requirements
- R1: After reset, `sum_o` is 0 and `carry_o`, `done_o` and `busy_o` are 0.
- R2: A word addition (`len_byte_i` = 0 at the accepted load) leaves `sum_o` = (`op_a_i` + `op_b_i`) mod 2^WORD_W. `done_o` rises exactly WORD_W clock edges after the load edge.
- R3: A byte addition (`len_byte_i` = 1 at the accepted load) uses only operand bits [BYTE_W-1:0]. It leaves the byte sum in `sum_o[BYTE_W-1:0]` with every higher bit 0, and `done_o` rises exactly BYTE_W edges after the load edge.
- R4: At `done_o`, `carry_o` is the carry out of the most significant active bit: bit WORD_W for a word, bit BYTE_W for a byte.
- R5: An accepted load clears the carry, so `carry_o` reads 0 in the cycle after the load and no carry survives from a previous addition.
- R6: A `load_i` strobe while `busy_o` is 1 is ignored: the operation in progress completes with its original operands and length.
- R7: `done_o` is high for exactly one cycle per addition, and `busy_o` is 0 in that cycle. A load in the done cycle is accepted.
- R8: While the block is idle and no load is given, `sum_o` and `carry_o` hold their values.
- R9: Bits are processed least significant first. After k of n bits, `sum_o` holds the low k sum bits in positions [n-1:n-k], with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start strobe; captures operands when idle |
| len_byte_i | input | 1 | Length select at load: 0 = word, 1 = byte |
| op_a_i | input | WORD_W | First operand |
| op_b_i | input | WORD_W | Second operand |
| sum_o | output | WORD_W | Result shift register |
| carry_o | output | 1 | Final carry of the last addition |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Addition in progress |

## Verification
The reference model predicts the full contents of `sum_o` on every clock, so the result register's partial contents reveal a wrong carry flip-flop, a wrong shift or a wrong insertion point. The first wrong sum bit shows up in the cycle after the edge that produced it, well before `done_o`. A bit counter that runs long or short moves the `done_o` pulse and the fall of `busy_o`, and the model sees this at that exact edge. A load that is wrongly accepted during an addition restarts the result register at once, so the mismatch appears in the next cycle.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic {
    LEN_WORD = 1'b0,
    LEN_BYTE = 1'b1
  } len_sel_e;
endpackage

// File: rtl/sadd_fa_cell.sv
module sadd_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = a_i ^ b_i ^ c_i;
    c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
  end
endmodule

// File: rtl/sadd_opnd_sreg.sv
module sadd_opnd_sreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             lsb_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_i)  q <= d_i;
    else if (shift_i) q <= {1'b0, q[WIDTH-1:1]};
  end

  assign lsb_o = q[0];
endmodule

// File: rtl/sadd_sum_sreg.sv
module sadd_sum_sreg #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              byte_mode_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] q;
  logic [WORD_W-1:0] nxt;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == WORD_W - 1) begin : g_top
      assign nxt[i] = byte_mode_i ? 1'b0 : bit_i;
    end else if (i == BYTE_W - 1) begin : g_byte_top
      assign nxt[i] = byte_mode_i ? bit_i : q[i+1];
    end else begin : g_mid
      assign nxt[i] = q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (clear_i) q <= '0;
    else if (shift_i) q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
  import sadd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic len_byte_i,
  output logic accept_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o,
  output logic byte_mode_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  len_sel_e         mode_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = (mode_q == LEN_BYTE) ? BYTE_LAST : WORD_LAST;
  assign accept_o = load_i & ~busy_q;
  assign last_o   = busy_q & (cnt_q == last_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= LEN_WORD;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= len_sel_e'(len_byte_i);
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign byte_mode_o = (mode_q == LEN_BYTE);
endmodule

// File: rtl/serial_word_adder.sv
module serial_word_adder #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              len_byte_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              carry_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int N_OPND = 2;

  logic              accept;
  logic              last;
  logic              byte_mode;
  logic              s_bit;
  logic              c_out;
  logic              carry_q;
  logic              fin_carry_q;
  logic [WORD_W-1:0] opnd_in [N_OPND];
  logic              opnd_bit [N_OPND];

  assign opnd_in[0] = op_a_i;
  assign opnd_in[1] = op_b_i;

  sadd_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .len_byte_i  (len_byte_i),
    .accept_o    (accept),
    .last_o      (last),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .byte_mode_o (byte_mode)
  );

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    sadd_opnd_sreg #(.WIDTH(WORD_W)) sreg_i (
      .clk     (clk),
      .rst     (rst),
      .load_i  (accept),
      .shift_i (busy_o),
      .d_i     (opnd_in[k]),
      .lsb_o   (opnd_bit[k])
    );
  end

  sadd_fa_cell fa_i (
    .a_i (opnd_bit[0]),
    .b_i (opnd_bit[1]),
    .c_i (carry_q),
    .s_o (s_bit),
    .c_o (c_out)
  );

  sadd_sum_sreg #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) sum_i (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (accept),
    .shift_i     (busy_o),
    .byte_mode_i (byte_mode),
    .bit_i       (s_bit),
    .q_o         (sum_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q     <= 1'b0;
      fin_carry_q <= 1'b0;
    end else if (accept) begin
      carry_q     <= 1'b0;
      fin_carry_q <= 1'b0;
    end else if (busy_o) begin
      carry_q <= c_out;
      if (last) fin_carry_q <= c_out;
    end
  end

  assign carry_o = fin_carry_q;
endmodule

// File: rtl/sadd_checker.sv
module sadd_checker #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              len_byte_i,
  input logic [WORD_W-1:0] sum_o,
  input logic              carry_o,
  input logic              done_o,
  input logic              busy_o
);
  int   run_cnt;
  logic mode_byte_q;
  int   target;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt     <= 0;
      mode_byte_q <= 1'b0;
    end else if (load_i && !busy_o) begin
      run_cnt     <= 0;
      mode_byte_q <= len_byte_i;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1;
    end
  end

  assign target = mode_byte_q ? BYTE_W : WORD_W;

  assert_done_len_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_cnt == target));

  assert_byte_upper_R3: assert property (@(posedge clk) disable iff (rst)
    mode_byte_q |-> (sum_o[WORD_W-1:BYTE_W] == '0));

  assert_start_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && !busy_o) |=> (busy_o && !carry_o));

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_cnt < target));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !load_i) |=> ($stable(sum_o) && $stable(carry_o)));
endmodule

bind serial_word_adder sadd_checker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .len_byte_i (len_byte_i),
  .sum_o      (sum_o),
  .carry_o    (carry_o),
  .done_o     (done_o),
  .busy_o     (busy_o)
);

// File: tb/serial_word_adder_tb.sv
module serial_word_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int B = 8;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic         len_byte_i = 1'b0;
  logic [W-1:0] op_a_i = '0;
  logic [W-1:0] op_b_i = '0;
  logic [W-1:0] sum_o;
  logic         carry_o;
  logic         done_o;
  logic         busy_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_adder #(.WORD_W(W), .BYTE_W(B)) dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .len_byte_i(len_byte_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .sum_o(sum_o), .carry_o(carry_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  // behavioural reference state
  bit          m_busy = 0, m_done = 0, m_carry = 0, m_byte = 0;
  int          m_k = 0, m_len = W;
  logic [63:0] m_full = '0;
  logic [63:0] m_sum  = '0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
    if (rst) begin
      m_busy = 0; m_done = 0; m_carry = 0; m_k = 0; m_len = W; m_byte = 0;
      m_sum = '0; m_full = '0;
    end else begin
      m_done = 0;
      if (load_i && !m_busy) begin
        m_byte  = len_byte_i;
        m_len   = len_byte_i ? B : W;
        m_full  = ({32'd0, op_a_i} & ((64'd1 << m_len) - 1)) +
                  ({32'd0, op_b_i} & ((64'd1 << m_len) - 1));
        m_busy  = 1; m_k = 0; m_sum = '0; m_carry = 0;
      end else if (m_busy) begin
        m_k++;
        m_sum = (m_full & ((64'd1 << m_k) - 1)) << (m_len - m_k);
        if (m_k == m_len) begin
          m_busy = 0; m_done = 1; m_carry = m_full[m_len];
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      string st;
      st = m_busy ? "R9 serial partial sum" :
           (m_done ? (m_byte ? "R3 byte sum" : "R2 word sum") : "R8 held sum");
      check(st, {32'd0, sum_o}, m_sum);
      check(m_busy ? "R5 carry cleared during add" : "R4 final carry",
            {63'd0, carry_o}, {63'd0, m_carry});
      check("R7 done pulse", {63'd0, done_o}, {63'd0, m_done});
      check("R6 busy flag", {63'd0, busy_o}, {63'd0, m_busy});
    end
  end

  task automatic start(logic [W-1:0] a, logic [W-1:0] b, bit byt);
    op_a_i = a; op_b_i = b; len_byte_i = byt; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!m_done) @(negedge clk);
  endtask

  task automatic do_add(logic [W-1:0] a, logic [W-1:0] b, bit byt, int gap);
    start(a, b, byt);
    wait_done();
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset sum", {32'd0, sum_o}, 64'd0);
    check("R1 reset flags", {60'd0, carry_o, done_o, busy_o, 1'b0}, 64'd0);
    @(negedge clk);

    // R2 and R4: all-ones plus one ripples the carry to bit 32
    do_add(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1);
    check("R4 word carry out", {63'd0, carry_o}, 64'd1);
    // R5: a zero add right after must show no stale carry
    do_add(32'h0, 32'h0, 1'b0, 1);
    check("R5 carry not carried over", {63'd0, carry_o}, 64'd0);
    // R3: byte with junk in upper operand bits
    do_add(32'hABCD_12FF, 32'h9999_9901, 1'b1, 1);
    check("R3 byte upper zero", {32'd0, sum_o}, 64'd0);
    check("R4 byte carry out", {63'd0, carry_o}, 64'd1);
    do_add(32'h0000_0012, 32'h0000_0034, 1'b1, 0);
    do_add(32'h8000_0000, 32'h8000_0000, 1'b0, 2);
    do_add(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 0);

    // R6: loads during a busy word add are ignored
    start(32'h1234_5678, 32'h1111_1111, 1'b0);
    repeat (4) @(negedge clk);
    start(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    repeat (10) @(negedge clk);
    start(32'h0000_00FF, 32'h0000_00FF, 1'b1);
    wait_done();
    check("R6 ignored load kept word sum", {32'd0, sum_o}, 64'h2345_6789);
    // R8: idle hold over several cycles
    repeat (5) @(negedge clk);
    check("R8 sum held idle", {32'd0, sum_o}, 64'h2345_6789);

    // random mix, back-to-back and gapped
    for (int i = 0; i < 200; i++) begin
      do_add($urandom, $urandom, 1'($urandom % 2), int'($urandom % 3));
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule